// File: doc/BRIEF.md
# Serial Receive Holding Register and Status Flags

This block sits behind the shift register of a serial receiver. When the receiver reports a finished frame with a good stop bit, the block copies the received byte into a holding register. It updates a small set of status flags: frame received, missing stop bit, byte lost, and a shared bit that carries either the parity check result or the ninth data bit. It also raises a receive interrupt-pending output. The CPU reads the holding register and the status word through strobes, and it can write the status flags.

The flags and the pending output are kept apart on purpose. A status read clears flags but never the pending bit. A software write to the flags never sets or clears the pending bit. Only a separate clear input from the interrupt controller removes a pending request. An unread marker follows whether the current byte has been fetched. Overrun detection is built on that marker.

Top module: `rx_frame_status`

## Requirements
- R1: After reset, holdData, the status word, dataUnread and rxPending are all zero.
- R2: A frameDone pulse loads frameData into holdData and sets status bit 0 (frame received) at the next clock edge. A frameErr pulse alone leaves holdData unchanged.
- R3: A frameDone pulse while dataUnread is 1 and rdHold is 0 in the same cycle sets status bit 2 (overrun). holdData then holds only the newest byte.
- R4: A frameErr pulse sets status bit 2-adjacent bit 1 (framing error). That bit stays set until a status read or a status write clears it.
- R5: An rdStatus pulse clears status bits 0, 1 and 2 and leaves bit 3 and rxPending unchanged. A flag-setting event in the same cycle takes precedence over the clear.
- R6: A wrStatus pulse loads wrFlags[3:0] into the status word and has no effect on rxPending. If rdStatus comes in the same cycle, the write wins. Frame events in the same cycle still set their bits.
- R7: rxPending is set by every frameDone; no mask input can block this. It is cleared only by pendClear, and frameDone in the same cycle wins over pendClear.
- R8: On frameDone, status bit 3 takes frameParBad when parityEn is 1 and frameBit9 when parityEn is 0. It keeps that value until the next frame or a status write.
- R9: dataUnread is set by frameDone and cleared by rdHold. frameDone in the same cycle wins over rdHold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle strobe: frame finished with a valid stop bit |
| frameErr | input | 1 | One-cycle strobe: stop bit missing in time |
| frameData | input | DATA_W | Byte from the shift register |
| frameBit9 | input | 1 | Ninth received data bit |
| frameParBad | input | 1 | Parity check failed for this frame |
| parityEn | input | 1 | Selects parity result (1) or ninth bit (0) for status bit 3 |
| rdStatus | input | 1 | CPU status read strobe |
| rdHold | input | 1 | CPU holding-register read strobe |
| wrStatus | input | 1 | CPU status write strobe |
| wrFlags | input | 4 | Status value written by the CPU |
| pendClear | input | 1 | Clear from the interrupt controller |
| holdData | output | DATA_W | Receive holding register |
| statusOut | output | 4 | Flags: bit 0 received, bit 1 framing, bit 2 overrun, bit 3 parity/ninth bit |
| dataUnread | output | 1 | Holding register not yet read |
| rxPending | output | 1 | Receive interrupt pending |

## Verification
The bench builds the block with DATA_W at its default of 8. With that width, full random bytes can be compared exactly against a reference model kept inside the bench. Random strobes reach the coincident cases: a read or write landing in the same cycle as a frame event, a holding-register read racing a new frame, and a pending clear racing a load. These cases decide the set-over-clear rules of R3, R5, R6, R7 and R9. Directed steps pin down the parity-versus-ninth-bit choice and the independence of the pending bit from status reads and writes.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int STAT_W = 4;
  localparam int DONE_B = 0;
  localparam int FERR_B = 1;
  localparam int OVR_B  = 2;
  localparam int XBIT_B = 3;

  typedef struct packed {
    logic load;
    logic setDone;
    logic setFerr;
    logic setOvr;
    logic clrFlags;
    logic wrFlags;
  } rxsStrobe_t;
endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameDone,
  input  logic       frameErr,
  input  logic       rdStatus,
  input  logic       rdHold,
  input  logic       wrStatus,
  input  logic       pendClear,
  output rxsStrobe_t strb,
  output logic       unreadQ,
  output logic       pendQ
);
  // decode strobes for the datapath
  always_comb begin
    strb          = '0;
    strb.load     = frameDone;
    strb.setDone  = frameDone;
    strb.setFerr  = frameErr;
    strb.setOvr   = frameDone && unreadQ && !rdHold;
    strb.clrFlags = rdStatus;
    strb.wrFlags  = wrStatus;
  end

  // unread marker: set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)          unreadQ <= 1'b0;
    else if (frameDone) unreadQ <= 1'b1;
    else if (rdHold)    unreadQ <= 1'b0;
  end

  // interrupt pending: only pendClear removes it
  always_ff @(posedge clk) begin
    if (!rstN)          pendQ <= 1'b0;
    else if (frameDone) pendQ <= 1'b1;
    else if (pendClear) pendQ <= 1'b0;
  end

  // R9
  unread_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> unreadQ);
  // R9
  unread_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdHold && !frameDone) |=> !unreadQ);
  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> pendQ);
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameDone && !pendClear) |=> $stable(pendQ));
endmodule

// File: rtl/rxs_dpath.sv
module rxs_dpath
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxsStrobe_t        strb,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameBit9,
  input  logic              frameParBad,
  input  logic              parityEn,
  input  logic [STAT_W-1:0] wrFlags,
  output logic [DATA_W-1:0] holdQ,
  output logic [STAT_W-1:0] statQ
);
  logic              xbitNext;
  logic [STAT_W-1:0] statNext;

  assign xbitNext = parityEn ? frameParBad : frameBit9;

  always_comb begin
    statNext = statQ;
    if (strb.clrFlags) begin
      statNext[DONE_B] = 1'b0;
      statNext[FERR_B] = 1'b0;
      statNext[OVR_B]  = 1'b0;
    end
    if (strb.wrFlags) statNext = wrFlags;
    if (strb.setFerr) statNext[FERR_B] = 1'b1;
    if (strb.setDone) statNext[DONE_B] = 1'b1;
    if (strb.setOvr)  statNext[OVR_B]  = 1'b1;
    if (strb.load)    statNext[XBIT_B] = xbitNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
      statQ <= '0;
    end else begin
      if (strb.load) holdQ <= frameData;
      statQ <= statNext;
    end
  end

  // R2
  load_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (holdQ == $past(frameData)) && statQ[DONE_B]);
  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(holdQ));
  // R3
  overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOvr |=> statQ[OVR_B]);
  // R4
  ferr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFerr |=> statQ[FERR_B]);
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlags && !strb.wrFlags && !strb.setDone) |=> !statQ[DONE_B]);
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic              frameErr,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameBit9,
  input  logic              frameParBad,
  input  logic              parityEn,
  input  logic              rdStatus,
  input  logic              rdHold,
  input  logic              wrStatus,
  input  logic [3:0]        wrFlags,
  input  logic              pendClear,
  output logic [DATA_W-1:0] holdData,
  output logic [3:0]        statusOut,
  output logic              dataUnread,
  output logic              rxPending
);
  rxsStrobe_t strb;

  rxs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameErr(frameErr),
    .rdStatus(rdStatus), .rdHold(rdHold), .wrStatus(wrStatus),
    .pendClear(pendClear), .strb(strb), .unreadQ(dataUnread),
    .pendQ(rxPending)
  );

  rxs_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .frameData(frameData),
    .frameBit9(frameBit9), .frameParBad(frameParBad), .parityEn(parityEn),
    .wrFlags(wrFlags), .holdQ(holdData), .statQ(statusOut)
  );

  // R6
  wr_no_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && !frameDone && !pendClear) |=> $stable(rxPending));
  // R5
  rd_no_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !frameDone && !pendClear) |=> $stable(rxPending));
endmodule

// File: tb/rx_frame_status_tb_top.sv
module rx_frame_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameDone = 0, frameErr = 0, frameBit9 = 0, frameParBad = 0, parityEn = 0;
  logic rdStatus = 0, rdHold = 0, wrStatus = 0, pendClear = 0;
  logic [DW-1:0] frameData = '0;
  logic [3:0] wrFlags = '0;
  logic [DW-1:0] holdData;
  logic [3:0] statusOut;
  logic dataUnread, rxPending;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [DW-1:0] expHold = '0;
  logic [3:0] expStat = '0;
  logic expUnread = 0, expPend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_status #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameErr(frameErr),
    .frameData(frameData), .frameBit9(frameBit9), .frameParBad(frameParBad),
    .parityEn(parityEn), .rdStatus(rdStatus), .rdHold(rdHold),
    .wrStatus(wrStatus), .wrFlags(wrFlags), .pendClear(pendClear),
    .holdData(holdData), .statusOut(statusOut), .dataUnread(dataUnread),
    .rxPending(rxPending)
  );

  function automatic logic [3:0] nextStat(input logic [3:0] s);
    logic [3:0] n = s;
    if (rdStatus) n[2:0] = 3'b000;                 // R5
    if (wrStatus) n = wrFlags;                      // R6
    if (frameErr) n[1] = 1'b1;                      // R4
    if (frameDone) begin
      n[0] = 1'b1;                                  // R2
      if (expUnread && !rdHold) n[2] = 1'b1;        // R3
      n[3] = parityEn ? frameParBad : frameBit9;    // R8
    end
    return n;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string ctx);
    cmp({ctx, " R2 holdData"}, 32'(holdData), 32'(expHold));
    cmp({ctx, " R5 statusOut"}, 32'(statusOut), 32'(expStat));
    cmp({ctx, " R9 dataUnread"}, 32'(dataUnread), 32'(expUnread));
    cmp({ctx, " R7 rxPending"}, 32'(rxPending), 32'(expPend));
  endtask

  // inputs already set at a negedge; advance one clock and update model
  task automatic tick(input string ctx);
    logic [3:0] ns = nextStat(expStat);
    if (frameDone) expHold = frameData;
    expStat = ns;
    if (frameDone) expUnread = 1'b1; else if (rdHold) expUnread = 1'b0;
    if (frameDone) expPend = 1'b1; else if (pendClear) expPend = 1'b0;
    @(posedge clk);
    @(negedge clk);
    {frameDone, frameErr, rdStatus, rdHold, wrStatus, pendClear} = '0;
    checkAll(ctx);
  endtask

  task automatic frame(input logic [DW-1:0] d, input logic b9, input logic pb);
    frameDone = 1; frameData = d; frameBit9 = b9; frameParBad = pb;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired, requirement R1 run incomplete");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmp("R1 reset holdData", 32'(holdData), 0);
    cmp("R1 reset statusOut", 32'(statusOut), 0);
    cmp("R1 reset dataUnread", 32'(dataUnread), 0);
    cmp("R1 reset rxPending", 32'(rxPending), 0);

    // R2 / R8: load with parity off, ninth bit 1
    parityEn = 0; frame(8'hA5, 1, 0); tick("R2 load");
    cmp("R8 ninth bit", 32'(statusOut[3]), 1);
    // R5: read status clears bit0, keeps pending and bit3
    rdStatus = 1; tick("R5 read");
    cmp("R5 pending kept", 32'(rxPending), 1);
    // R3: second frame while unread
    frame(8'h3C, 0, 0); tick("R3 overrun");
    cmp("R3 overrun bit", 32'(statusOut[2]), 1);
    cmp("R3 newest byte", 32'(holdData), 32'h3C);
    // R9 + R3: read hold in same cycle as frame -> no new overrun
    rdStatus = 1; tick("R5 clear");
    rdHold = 1; frame(8'h11, 0, 0); tick("R9 race");
    cmp("R3 no overrun on race", 32'(statusOut[2]), 0);
    // R4: framing error leaves holdData
    frameErr = 1; tick("R4 ferr");
    cmp("R4 ferr bit", 32'(statusOut[1]), 1);
    cmp("R4 hold unchanged", 32'(holdData), 32'h11);
    tick("R4 sticky");
    cmp("R4 ferr sticky", 32'(statusOut[1]), 1);
    // R7: clear pending, then R6 write must not set it
    pendClear = 1; tick("R7 clear");
    cmp("R7 pending cleared", 32'(rxPending), 0);
    wrStatus = 1; wrFlags = 4'b0001; tick("R6 write");
    cmp("R6 write no pend", 32'(rxPending), 0);
    cmp("R6 write value", 32'(statusOut), 32'h1);
    // R8: parity enabled selects parity result
    parityEn = 1; frame(8'h5A, 0, 1); tick("R8 par bad");
    cmp("R8 parity err", 32'(statusOut[3]), 1);
    frame(8'h5B, 1, 0); tick("R8 par ok");
    cmp("R8 parity ok", 32'(statusOut[3]), 0);
    // R7: frame wins over pendClear
    pendClear = 1; frame(8'h77, 0, 0); tick("R7 race");
    cmp("R7 set wins", 32'(rxPending), 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom;
      parityEn  = r[0];
      frameDone = (r[3:1] == 3'd0);
      frameErr  = (r[6:4] == 3'd0);
      rdStatus  = (r[9:7] == 3'd0);
      rdHold    = (r[11:10] == 2'd0);
      wrStatus  = (r[15:12] == 4'd0);
      pendClear = (r[18:16] == 3'd0);
      frameBit9 = r[19];
      frameParBad = r[20];
      wrFlags   = r[24:21];
      frameData = DW'($urandom);
      tick("random");
    end
    finishRun();
  end
endmodule